// File: doc/BRIEF.md
# Upward-Growing Call/Return Stack Sequencer

This block holds the stack pointer of an 8-bit microcontroller and carries out the stack traffic for the core. The core presents one command at a time over a valid/ready handshake. The six commands are push byte, pop byte, subroutine call, interrupt entry, return, and return from interrupt. The block then drives a byte-wide internal RAM port for as many cycles as the command needs. When a command finishes, it pulses a completion flag. A popped byte or a restored 16-bit program counter is held stable on the outputs until the next pop or return replaces it.

The stack pointer always addresses the most recently stored byte and grows toward higher addresses. Software can read the stack pointer and overwrite it through a special-function-register port at address $81. Calls and interrupt entries store the return address with its low byte at the lower address. Only the program counter is saved; saving any other context is left to software. A return from interrupt also pulses an in-service-clear output, in the same cycle as its completion flag.

Top module: `stk_unit`

## Requirements
- R1: After reset the stack pointer is $07, `cmd_ready_o` is 1, and `done_o` and `isr_clr_o` are 0.
- R2: While `sfr_addr_i` is $81, `sfr_rdata_o` shows the stack pointer; at any other address it shows 0. A write at $81 in an idle cycle with no accepted command loads the stack pointer. A write at any other address leaves the stack pointer unchanged.
- R3: Push (`cmd_i`=0) increments the stack pointer and then writes `push_data_i` at the new address. `cmd_ready_o` is low for exactly 1 cycle.
- R4: Pop (`cmd_i`=1) reads the byte at the stack pointer and then decrements the pointer. The byte appears on `pop_data_o` when `done_o` pulses. `cmd_ready_o` is low for 2 cycles.
- R5: Call (`cmd_i`=2) and interrupt entry (`cmd_i`=3) store `pc_i[7:0]` at SP+1 and then `pc_i[15:8]` at SP+2. The pointer ends 2 higher, and `cmd_ready_o` is low for 2 cycles.
- R6: Return (`cmd_i`=4) and return from interrupt (`cmd_i`=5) read the high byte at SP and then the low byte at SP-1. `pc_o` becomes {high, low}, the pointer ends 2 lower, and `cmd_ready_o` is low for 3 cycles.
- R7: The stack pointer wraps from $FF to $00 on increment and from $00 to $FF on decrement, with no error indication.
- R8: `isr_clr_o` pulses together with `done_o` only at the end of a return from interrupt, never for a plain return or an interrupt entry.
- R9: An SFR write at $81 while a command is in progress is ignored. The pointer reflects only the command's own steps.
- R10: The RAM write and read strobes are never both high and are both low while idle. Command codes 6 and 7 are not accepted and cause no RAM access and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_i | input | 3 | Command code |
| pc_i | input | 16 | Program counter to save on call/interrupt entry |
| push_data_i | input | 8 | Byte to push |
| cmd_ready_o | output | 1 | Idle and able to accept a command |
| done_o | output | 1 | One-cycle pulse when a command completes |
| pop_data_o | output | 8 | Last popped byte |
| pc_o | output | 16 | Last restored program counter |
| isr_clr_o | output | 1 | In-service-clear pulse at the end of a return from interrupt |
| sfr_addr_i | input | 8 | SFR address |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data |
| ram_addr_o | output | 8 | RAM address |
| ram_we_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | 8 | RAM write data |
| ram_re_o | output | 1 | RAM read strobe; data is returned on the next cycle |
| ram_rdata_i | input | 8 | RAM read data |

## Verification
The hardest case to reach is an SFR write to the stack pointer that collides with a multi-cycle return. The bench starts a return and, in the cycle just after acceptance, raises a write of an unrelated value at $81. It then checks that the final pointer is exactly two below its starting value. Wrap-around is reached by loading $FF or $00 through the SFR port and then pushing or popping across the boundary. The bench checks where the byte landed in its own RAM model.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    CMD_PUSH = 3'd0,
    CMD_POP  = 3'd1,
    CMD_CALL = 3'd2,
    CMD_INTR = 3'd3,
    CMD_RET  = 3'd4,
    CMD_RETI = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_A,
    ST_B,
    ST_C
  } st_e;

  function automatic logic cmd_legal(logic [2:0] c);
    return c <= 3'd5;
  endfunction
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] RST_VAL = 8'h07
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          dec_i,
  input  logic          ld_i,
  input  logic [AW-1:0] ld_val_i,
  output logic [AW-1:0] sp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_o <= RST_VAL;
    else if (inc_i) sp_o <= sp_o + AW'(1);
    else if (dec_i) sp_o <= sp_o - AW'(1);
    else if (ld_i) sp_o <= ld_val_i;
  end
endmodule

// File: rtl/stk_sfr.sv
module stk_sfr #(
  parameter int unsigned AW = 8,
  parameter int unsigned SFR_AW = 8,
  parameter logic [SFR_AW-1:0] SP_ADDR = 8'h81
) (
  input  logic [SFR_AW-1:0] sfr_addr_i,
  input  logic              sfr_wr_i,
  input  logic [AW-1:0]     sfr_wdata_i,
  input  logic              free_i,
  input  logic [AW-1:0]     sp_i,
  output logic [AW-1:0]     sfr_rdata_o,
  output logic              ld_o,
  output logic [AW-1:0]     ld_val_o
);
  logic hit;
  assign hit         = (sfr_addr_i == SP_ADDR);
  assign sfr_rdata_o = hit ? sp_i : '0;
  assign ld_o        = sfr_wr_i && hit && free_i;
  assign ld_val_o    = sfr_wdata_i;
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned PCW = 2 * DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cmd_valid_i,
  input  logic [2:0]     cmd_i,
  input  logic [PCW-1:0] pc_i,
  input  logic [DW-1:0]  push_data_i,
  input  logic [DW-1:0]  sp_i,
  output logic           cmd_ready_o,
  output logic           accept_o,
  output logic           sp_inc_o,
  output logic           sp_dec_o,
  output logic [DW-1:0]  ram_addr_o,
  output logic           ram_we_o,
  output logic [DW-1:0]  ram_wdata_o,
  output logic           ram_re_o,
  input  logic [DW-1:0]  ram_rdata_i,
  output logic [DW-1:0]  pop_data_o,
  output logic [PCW-1:0] pc_o,
  output logic           done_o,
  output logic           isr_clr_o
);
  st_e             st_q, st_d;
  cmd_e            cmd_q;
  logic [PCW-1:0]  pc_q;
  logic [DW-1:0]   data_q, hi_q;
  logic            fin, hi_ld, pc_ld, pop_ld;

  assign cmd_ready_o = (st_q == ST_IDLE);
  assign accept_o    = cmd_ready_o && cmd_valid_i && cmd_legal(cmd_i);

  always_comb begin
    st_d        = st_q;
    ram_we_o    = 1'b0;
    ram_re_o    = 1'b0;
    ram_addr_o  = sp_i;
    ram_wdata_o = data_q;
    sp_inc_o    = 1'b0;
    sp_dec_o    = 1'b0;
    fin         = 1'b0;
    hi_ld       = 1'b0;
    pc_ld       = 1'b0;
    pop_ld      = 1'b0;
    case (st_q)
      ST_IDLE: if (accept_o) st_d = ST_A;
      ST_A: begin
        case (cmd_q)
          CMD_PUSH: begin
            ram_we_o   = 1'b1;
            ram_addr_o = sp_i + DW'(1);
            sp_inc_o   = 1'b1;
            fin        = 1'b1;
            st_d       = ST_IDLE;
          end
          CMD_CALL, CMD_INTR: begin
            ram_we_o    = 1'b1;
            ram_addr_o  = sp_i + DW'(1);
            ram_wdata_o = pc_q[DW-1:0];
            sp_inc_o    = 1'b1;
            st_d        = ST_B;
          end
          default: begin
            ram_re_o = 1'b1;
            sp_dec_o = 1'b1;
            st_d     = ST_B;
          end
        endcase
      end
      ST_B: begin
        case (cmd_q)
          CMD_CALL, CMD_INTR: begin
            ram_we_o    = 1'b1;
            ram_addr_o  = sp_i + DW'(1);
            ram_wdata_o = pc_q[PCW-1:DW];
            sp_inc_o    = 1'b1;
            fin         = 1'b1;
            st_d        = ST_IDLE;
          end
          CMD_POP: begin
            pop_ld = 1'b1;
            fin    = 1'b1;
            st_d   = ST_IDLE;
          end
          default: begin
            hi_ld    = 1'b1;
            ram_re_o = 1'b1;
            sp_dec_o = 1'b1;
            st_d     = ST_C;
          end
        endcase
      end
      ST_C: begin
        pc_ld = 1'b1;
        fin   = 1'b1;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cmd_q      <= CMD_PUSH;
      pc_q       <= '0;
      data_q     <= '0;
      hi_q       <= '0;
      pop_data_o <= '0;
      pc_o       <= '0;
      done_o     <= 1'b0;
      isr_clr_o  <= 1'b0;
    end else begin
      st_q      <= st_d;
      done_o    <= fin;
      isr_clr_o <= pc_ld && (cmd_q == CMD_RETI);
      if (accept_o) begin
        cmd_q  <= cmd_e'(cmd_i);
        pc_q   <= pc_i;
        data_q <= push_data_i;
      end
      if (hi_ld)  hi_q       <= ram_rdata_i;
      if (pop_ld) pop_data_o <= ram_rdata_i;
      if (pc_ld)  pc_o       <= {hi_q, ram_rdata_i};
    end
  end
endmodule

// File: rtl/stk_unit.sv
module stk_unit #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SFR_AW = 8,
  parameter logic [SFR_AW-1:0] SP_SFR_ADDR = 8'h81,
  parameter logic [DATA_W-1:0] SP_RST = 8'h07,
  localparam int unsigned PC_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic              cmd_ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              isr_clr_o,
  input  logic [SFR_AW-1:0] sfr_addr_i,
  input  logic              sfr_wr_i,
  input  logic [DATA_W-1:0] sfr_wdata_i,
  output logic [DATA_W-1:0] sfr_rdata_o,
  output logic [DATA_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic              ram_re_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  logic [DATA_W-1:0] sp_q, ld_val;
  logic              sp_inc, sp_dec, sp_ld, accept;

  stk_ptr #(.AW(DATA_W), .RST_VAL(SP_RST)) u_ptr (
    .clk_i, .rst_ni,
    .inc_i(sp_inc), .dec_i(sp_dec), .ld_i(sp_ld), .ld_val_i(ld_val),
    .sp_o(sp_q)
  );

  stk_sfr #(.AW(DATA_W), .SFR_AW(SFR_AW), .SP_ADDR(SP_SFR_ADDR)) u_sfr (
    .sfr_addr_i, .sfr_wr_i, .sfr_wdata_i,
    .free_i(cmd_ready_o && !accept),
    .sp_i(sp_q), .sfr_rdata_o, .ld_o(sp_ld), .ld_val_o(ld_val)
  );

  stk_seq #(.DW(DATA_W)) u_seq (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_i, .pc_i, .push_data_i,
    .sp_i(sp_q), .cmd_ready_o, .accept_o(accept),
    .sp_inc_o(sp_inc), .sp_dec_o(sp_dec),
    .ram_addr_o, .ram_we_o, .ram_wdata_o, .ram_re_o, .ram_rdata_i,
    .pop_data_o, .pc_o, .done_o, .isr_clr_o
  );
endmodule

// File: rtl/stk_unit_chk.sv
module stk_unit_chk #(
  parameter int unsigned DW = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cmd_valid_i,
  input logic [2:0]      cmd_i,
  input logic [2*DW-1:0] pc_i,
  input logic            cmd_ready_o,
  input logic            ram_we_o,
  input logic            ram_re_o,
  input logic [DW-1:0]   ram_addr_o,
  input logic [DW-1:0]   ram_wdata_o,
  input logic            done_o,
  input logic            isr_clr_o,
  input logic [DW-1:0]   sp_q
);
  logic acc;
  assign acc = cmd_valid_i && cmd_ready_o;

  // R10
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && ram_re_o));
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> (!ram_we_o && !ram_re_o));
  // R3
  push_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_i == 3'd0) |=> (ram_we_o && ram_addr_o == ($past(sp_q) + DW'(1))));
  // R4
  pop_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_i == 3'd1) |=> (ram_re_o && ram_addr_o == $past(sp_q)));
  // R5
  call_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (cmd_i == 3'd2 || cmd_i == 3'd3)) |=>
      (ram_we_o && ram_addr_o == ($past(sp_q) + DW'(1)) && ram_wdata_o == $past(pc_i[DW-1:0])));
  // R6
  ret_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && (cmd_i == 3'd4 || cmd_i == 3'd5)) |=> (ram_re_o && ram_addr_o == $past(sp_q)));
  // R8
  isr_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_clr_o |-> done_o);
endmodule

bind stk_unit stk_unit_chk #(.DW(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
  .pc_i(pc_i), .cmd_ready_o(cmd_ready_o), .ram_we_o(ram_we_o), .ram_re_o(ram_re_o),
  .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o), .done_o(done_o),
  .isr_clr_o(isr_clr_o), .sp_q(sp_q)
);

// File: tb/tb_stk_unit.sv
module tb_stk_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd = '0;
  logic [15:0] pc = '0;
  logic [7:0]  pdata = '0;
  logic        ready, done, isr_clr, ram_we, ram_re;
  logic [7:0]  pop_data, sfr_rdata, ram_addr, ram_wdata;
  logic [15:0] pc_out;
  logic [7:0]  sfr_addr = 8'h81, sfr_wdata = '0;
  logic        sfr_wr = 1'b0;
  logic [7:0]  ram_rdata = '0;
  logic [7:0]  mem [256];
  int n_chk = 0, n_bad = 0, ram_ops = 0;
  int busy;
  logic last_done, last_isr, early_isr;

  always #2 clk = ~clk;

  stk_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .pc_i(pc),
    .push_data_i(pdata), .cmd_ready_o(ready), .done_o(done), .pop_data_o(pop_data),
    .pc_o(pc_out), .isr_clr_o(isr_clr), .sfr_addr_i(sfr_addr), .sfr_wr_i(sfr_wr),
    .sfr_wdata_i(sfr_wdata), .sfr_rdata_o(sfr_rdata), .ram_addr_o(ram_addr),
    .ram_we_o(ram_we), .ram_wdata_o(ram_wdata), .ram_re_o(ram_re), .ram_rdata_i(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_we) mem[ram_addr] <= ram_wdata;
    if (ram_re) ram_rdata <= mem[ram_addr];
    if (ram_we || ram_re) ram_ops <= ram_ops + 1;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic get_sp(output logic [7:0] v);
    sfr_addr = 8'h81;
    #1 v = sfr_rdata;
  endtask

  task automatic sfr_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0; sfr_addr = 8'h81;
  endtask

  task automatic run_cmd(logic [2:0] c, logic [15:0] p, logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; pc = p; pdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    busy = 0; early_isr = 1'b0;
    while (!ready && busy < 20) begin
      busy++;
      if (isr_clr) early_isr = 1'b1;
      @(negedge clk);
    end
    last_done = done; last_isr = isr_clr;
  endtask

  task automatic t_reset;
    logic [7:0] s;
    get_sp(s);
    chk("R1 sp", s, 8'h07);
    chk("R1 ready", ready, 1);
    chk("R1 done", done, 0);
    chk("R1 isr_clr", isr_clr, 0);
  endtask

  task automatic t_push_pop;
    logic [7:0] s;
    run_cmd(3'd0, 16'h0, 8'hA5);
    get_sp(s);
    chk("R3 busy", busy, 1);
    chk("R3 done", last_done, 1);
    chk("R3 mem", mem[8'h08], 8'hA5);
    chk("R3 sp", s, 8'h08);
    run_cmd(3'd1, 16'h0, 8'h00);
    get_sp(s);
    chk("R4 busy", busy, 2);
    chk("R4 done", last_done, 1);
    chk("R4 data", pop_data, 8'hA5);
    chk("R4 sp", s, 8'h07);
  endtask

  task automatic t_call_ret;
    logic [7:0] s;
    run_cmd(3'd2, 16'h1234, 8'h00);
    get_sp(s);
    chk("R5 call busy", busy, 2);
    chk("R5 call low", mem[8'h08], 8'h34);
    chk("R5 call high", mem[8'h09], 8'h12);
    chk("R5 call sp", s, 8'h09);
    chk("R8 call no isr_clr", last_isr | early_isr, 0);
    run_cmd(3'd3, 16'hABCD, 8'h00);
    get_sp(s);
    chk("R5 intr low", mem[8'h0A], 8'hCD);
    chk("R5 intr high", mem[8'h0B], 8'hAB);
    chk("R5 intr sp", s, 8'h0B);
    chk("R8 intr no isr_clr", last_isr | early_isr, 0);
    run_cmd(3'd5, 16'h0, 8'h00);
    get_sp(s);
    chk("R6 reti busy", busy, 3);
    chk("R6 reti pc", pc_out, 16'hABCD);
    chk("R6 reti sp", s, 8'h09);
    chk("R8 reti isr_clr with done", {last_done, last_isr}, 2'b11);
    chk("R8 reti not early", early_isr, 0);
    @(negedge clk);
    chk("R8 isr_clr one cycle", isr_clr, 0);
    run_cmd(3'd4, 16'h0, 8'h00);
    get_sp(s);
    chk("R6 ret pc", pc_out, 16'h1234);
    chk("R6 ret sp", s, 8'h07);
    chk("R8 ret no isr_clr", last_isr | early_isr, 0);
  endtask

  task automatic t_sfr;
    logic [7:0] s;
    sfr_write(8'h81, 8'h40);
    get_sp(s);
    chk("R2 load", s, 8'h40);
    sfr_write(8'h80, 8'h11);
    get_sp(s);
    chk("R2 other addr no effect", s, 8'h40);
    sfr_addr = 8'h80;
    #1 chk("R2 other addr reads 0", sfr_rdata, 0);
    sfr_addr = 8'h81;
  endtask

  task automatic t_wrap;
    logic [7:0] s;
    sfr_write(8'h81, 8'hFF);
    run_cmd(3'd0, 16'h0, 8'h5A);
    get_sp(s);
    chk("R7 push wrap mem", mem[8'h00], 8'h5A);
    chk("R7 push wrap sp", s, 8'h00);
    run_cmd(3'd1, 16'h0, 8'h00);
    get_sp(s);
    chk("R7 pop wrap data", pop_data, 8'h5A);
    chk("R7 pop wrap sp", s, 8'hFF);
  endtask

  task automatic t_busy_sfr;
    logic [7:0] s;
    sfr_write(8'h81, 8'h20);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = 3'd4;
    @(negedge clk);
    cmd_valid = 1'b0;
    sfr_addr = 8'h81; sfr_wdata = 8'h77; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
    while (!ready) @(negedge clk);
    get_sp(s);
    chk("R9 write while busy ignored", s, 8'h1E);
  endtask

  task automatic t_illegal;
    logic [7:0] s, s0;
    int ops0;
    get_sp(s0);
    ops0 = ram_ops;
    @(negedge clk);
    cmd_valid = 1'b1; cmd = 3'd6;
    @(negedge clk);
    chk("R10 code 6 not accepted", ready, 1);
    cmd = 3'd7;
    @(negedge clk);
    chk("R10 code 7 not accepted", ready, 1);
    cmd_valid = 1'b0;
    @(negedge clk);
    get_sp(s);
    chk("R10 sp unchanged", s, s0);
    chk("R10 no ram access", ram_ops, ops0);
  endtask

  initial begin
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_pop();
    t_call_ret();
    t_sfr();
    t_wrap();
    t_busy_sfr();
    t_illegal();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule